// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces the external memory bus of a classic 8-bit controller core whose machine cycle lasts twelve oscillator periods, grouped as six states of two periods each. It runs on the oscillator clock and splits every machine cycle into two halves. Each half opens with an address phase: an address latch enable pulse while the shared low port carries the low address byte and the high port carries the upper byte. A code read strobe, a data read strobe or a data write strobe follows it.

At the last oscillator period of each machine cycle the core presents a code fetch request with its address. It may also present an external data transfer request with a data address, a direction and write data. An external data transfer takes two machine cycles. The second half of the first cycle puts the data address on the bus. In the first half of the second cycle, no latch pulse is issued and the read or write strobe is active instead. A select input decides whether the low 4 KB of code space is served internally, in which case no code strobe is issued. The port is released whenever external memory has to drive it. The byte read back is presented with a one-period valid pulse.

Top module: `mxb_bus_seq`

## Requirements
- R1: With no data transfer under way, `ale` is high for two oscillator periods at periods 0, 1, 6 and 7 of every 12-period machine cycle. Its rising edges are six periods apart.
- R2: A data transfer spans two machine cycles and has three latch pulses in total. The pulse at the start of the second cycle is omitted, so two rising edges are 12 periods apart.
- R3: While `ale` is high, `p0_oe` is 1 and `p0_out` carries the low address byte. The byte stays driven and unchanged in the period after `ale` falls.
- R4: The address captured as {`p2_out`,`p0_out`} at an `ale` falling edge is the fetch address in the first half of a plain cycle and the fetch address plus one (wrapping at FFFFh) in the second half. In a transfer, the second half of the first cycle carries the data address. `p2_out` keeps the data address high byte throughout the strobe.
- R5: A half-cycle code read is external when `rom_en` is 0, or when its address is 1000h or above. Only then is `psen_n` low, for periods 3 to 5 of that half. An external fetch therefore gives two `psen_n` pulses per machine cycle.
- R6: `psen_n` stays high when `fetch_req` is 0, for internal code reads, and during data strobes. At most one of `psen_n`, `rd_n` and `wr_n` is low at any time.
- R7: `rd_n` (when `xdata_wr` is 0) or `wr_n` (when `xdata_wr` is 1) is low only during periods 0 to 5 of the second machine cycle of a transfer. During a write, `p0_oe` is 1 and `p0_out` equals the write data throughout the low window.
- R8: `p0_oe` is 0 whenever `psen_n` or `rd_n` is low.
- R9: `p0_in` is sampled in the last period of each `psen_n` or `rd_n` window. In the next period, `rdata_vld` is high for one period and `rdata` holds that byte.
- R10: After reset, `ale` and `p0_oe` are 0, `psen_n`, `rd_n` and `wr_n` are 1, `rdata_vld` is 0, and `cyc_end` is 1. `cyc_end` is high in the last period of each machine cycle, when requests are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_req | input | 1 | Code fetch wanted in the coming machine cycle |
| code_addr | input | 16 | Code fetch address |
| xdata_req | input | 1 | Start an external data transfer |
| xdata_wr | input | 1 | Transfer direction, 1 = write |
| data_addr | input | 16 | External data address |
| wdata | input | 8 | Write data |
| rom_en | input | 1 | 1 = low 4 KB of code is internal |
| p0_in | input | 8 | Value read from the shared port |
| cyc_end | output | 1 | Last period of the machine cycle |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Shared port output value |
| p0_oe | output | 1 | Shared port output enable |
| p2_out | output | 8 | High address byte |
| rdata | output | 8 | Byte read from external memory |
| rdata_vld | output | 1 | One-period valid for `rdata` |

## Verification
The bench builds the block with its default parameters: two periods per state, six states, a 16-bit address, an 8-bit port and 4 KB of internal code. These values put both half-cycles of a fetch within one machine cycle. A single cycle therefore straddles the 0FFFh/1000h internal boundary, and another wraps from FFFFh to 0000h. An external memory model in the bench answers from the latched address, so every read-back byte also checks the address phase that preceded it.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    // What a half machine cycle is used for
    typedef enum logic [1:0] {
        HK_FETCH  = 2'd0,
        HK_DADDR  = 2'd1,
        HK_STROBE = 2'd2
    } half_kind_e;

endpackage

// File: rtl/mxb_timebase.sv
module mxb_timebase #(
    parameter int MC_TICKS = 12,
    parameter int TW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] tick_q,
    output logic [TW-1:0] pos_q,
    output logic [TW-1:0] pos_n,
    output logic          at_start_n,
    output logic          at_mid_n,
    output logic          last_q
);
    localparam logic [TW-1:0] LAST   = TW'(MC_TICKS - 1);
    localparam logic [TW-1:0] HALF_T = TW'(MC_TICKS / 2);

    logic [TW-1:0] tick_d;

    always_comb begin
        tick_d     = (tick_q == LAST) ? '0 : tick_q + 1'b1;
        pos_n      = (tick_d >= HALF_T) ? tick_d - HALF_T : tick_d;
        pos_q      = (tick_q >= HALF_T) ? tick_q - HALF_T : tick_q;
        at_start_n = (tick_d == '0);
        at_mid_n   = (tick_d == HALF_T);
        last_q     = (tick_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= LAST;
        else        tick_q <= tick_d;
    end

    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q == LAST) |=> (tick_q == '0));   // R10

endmodule

// File: rtl/mxb_code_route.sv
module mxb_code_route #(
    parameter int ADDR_W        = 16,
    parameter int INT_ROM_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_en,
    input  logic              fetch_on,
    output logic              ext
);
    generate
        if (INT_ROM_BYTES <= 0) begin : g_all_ext
            assign ext = fetch_on;
        end else begin : g_rom
            localparam logic [ADDR_W:0] LIM = (ADDR_W + 1)'(INT_ROM_BYTES);
            assign ext = fetch_on && (!rom_en || ({1'b0, addr} >= LIM));
        end
    endgenerate

endmodule

// File: rtl/mxb_bus_seq.sv
module mxb_bus_seq
    import mxb_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int STATE_TICKS   = 2,
    parameter int STATES        = 6,
    parameter int INT_ROM_BYTES = 4096
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_req,
    input  logic [ADDR_W-1:0]    code_addr,
    input  logic                 xdata_req,
    input  logic                 xdata_wr,
    input  logic [ADDR_W-1:0]    data_addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 rom_en,
    input  logic [DATA_W-1:0]    p0_in,
    output logic                 cyc_end,
    output logic                 ale,
    output logic                 psen_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic [DATA_W-1:0]    p0_out,
    output logic                 p0_oe,
    output logic [ADDR_W-DATA_W-1:0] p2_out,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rdata_vld
);
    localparam int MC_TICKS = STATE_TICKS * STATES;
    localparam int HALF     = MC_TICKS / 2;
    localparam int TW       = $clog2(MC_TICKS + 1);
    localparam logic [TW-1:0] ALE_END  = TW'(STATE_TICKS);
    localparam logic [TW-1:0] HALF_END = TW'(HALF - 1);

    typedef struct packed {
        logic              mv1;
        logic              mv2;
        logic              mv_wr;
        logic              fetch;
        logic [ADDR_W-1:0] caddr;
        logic [ADDR_W-1:0] xaddr;
        logic [ADDR_W-1:0] cur;
        logic [DATA_W-1:0] wd;
        half_kind_e        kind;
        logic              cur_ext;
        logic              ale;
        logic              psen_n;
        logic              rd_n;
        logic              wr_n;
        logic              p0_oe;
        logic [DATA_W-1:0] p0;
        logic [DATA_W-1:0] rdata;
        logic              rvld;
    } st_t;

    st_t q, d;

    logic [TW-1:0] tick_q, pos_q, pos_n;
    logic          at_start_n, at_mid_n, last_q;

    mxb_timebase #(.MC_TICKS(MC_TICKS), .TW(TW)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_q(tick_q), .pos_q(pos_q),
        .pos_n(pos_n), .at_start_n(at_start_n), .at_mid_n(at_mid_n),
        .last_q(last_q)
    );

    // Plan of the next half cycle
    half_kind_e        plan_kind;
    logic [ADDR_W-1:0] plan_addr;
    logic              plan_fetch;
    logic              plan_ext;

    always_comb begin
        plan_kind  = q.kind;
        plan_addr  = q.cur;
        plan_fetch = 1'b0;
        if (at_start_n) begin
            if (q.mv1) begin
                plan_kind = HK_STROBE;
                plan_addr = q.xaddr;
            end else begin
                plan_kind  = HK_FETCH;
                plan_addr  = code_addr;
                plan_fetch = fetch_req;
            end
        end else if (at_mid_n) begin
            if (q.mv1) begin
                plan_kind = HK_DADDR;
                plan_addr = q.xaddr;
            end else if (q.mv2) begin
                plan_kind  = HK_FETCH;
                plan_addr  = q.caddr;
                plan_fetch = q.fetch;
            end else begin
                plan_kind  = HK_FETCH;
                plan_addr  = q.caddr + 1'b1;
                plan_fetch = q.fetch;
            end
        end
    end

    mxb_code_route #(.ADDR_W(ADDR_W), .INT_ROM_BYTES(INT_ROM_BYTES)) u_route (
        .addr(plan_addr), .rom_en(rom_en), .fetch_on(plan_fetch), .ext(plan_ext)
    );

    always_comb begin
        d      = q;
        d.rvld = 1'b0;

        // capture the byte in the last period of a read window
        if (pos_q == HALF_END &&
            ((q.kind == HK_FETCH && q.cur_ext) || (q.kind == HK_STROBE && !q.mv_wr))) begin
            d.rdata = p0_in;
            d.rvld  = 1'b1;
        end

        if (at_start_n) begin
            d.fetch = fetch_req;
            d.caddr = code_addr;
            if (q.mv1) begin
                d.mv1 = 1'b0;
                d.mv2 = 1'b1;
            end else begin
                d.mv2   = 1'b0;
                d.mv1   = xdata_req;
                d.mv_wr = xdata_wr;
                d.xaddr = data_addr;
                d.wd    = wdata;
            end
        end

        if (at_start_n || at_mid_n) begin
            d.kind    = plan_kind;
            d.cur     = plan_addr;
            d.cur_ext = plan_ext;
        end

        // registered pin values for the coming period
        d.ale    = 1'b0;
        d.psen_n = 1'b1;
        d.rd_n   = 1'b1;
        d.wr_n   = 1'b1;
        d.p0_oe  = 1'b0;
        if (d.kind == HK_STROBE) begin
            if (d.mv_wr) begin
                d.wr_n  = 1'b0;
                d.p0    = d.wd;
                d.p0_oe = 1'b1;
            end else begin
                d.rd_n = 1'b0;
            end
        end else begin
            if (pos_n < ALE_END) d.ale = 1'b1;
            if (pos_n <= ALE_END) begin
                d.p0    = d.cur[DATA_W-1:0];
                d.p0_oe = 1'b1;
            end else if (d.kind == HK_FETCH && d.cur_ext) begin
                d.psen_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.kind   <= HK_FETCH;
            q.psen_n <= 1'b1;
            q.rd_n   <= 1'b1;
            q.wr_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cyc_end   = last_q;
    assign ale       = q.ale;
    assign psen_n    = q.psen_n;
    assign rd_n      = q.rd_n;
    assign wr_n      = q.wr_n;
    assign p0_out    = q.p0;
    assign p0_oe     = q.p0_oe;
    assign p2_out    = q.cur[ADDR_W-1:DATA_W];
    assign rdata     = q.rdata;
    assign rdata_vld = q.rvld;

    AST_ALE_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (p0_oe && rd_n && wr_n && psen_n));                    // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (p0_oe && $stable(p0_out)));                    // R3
    AST_PORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !p0_oe);                                // R8
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~psen_n, ~rd_n, ~wr_n}));                            // R6
    AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> (p0_oe && $stable(p0_out)));      // R7
    AST_NO_ALE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !ale);                                    // R2
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_vld |=> !rdata_vld);                                     // R9
    AST_ALE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |=> !ale);                                          // R1

endmodule

// File: tb/tb_mxb_bus_seq.sv
`timescale 1ns/1ps
module tb_mxb_bus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0, xdata_req = 1'b0, xdata_wr = 1'b0, rom_en = 1'b0;
    logic [15:0] code_addr = '0, data_addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  p0_in;
    logic        cyc_end, ale, psen_n, rd_n, wr_n, p0_oe, rdata_vld;
    logic [7:0]  p0_out, p2_out, rdata;

    always #5 clk = ~clk;

    mxb_bus_seq dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .code_addr(code_addr),
        .xdata_req(xdata_req), .xdata_wr(xdata_wr), .data_addr(data_addr),
        .wdata(wdata), .rom_en(rom_en), .p0_in(p0_in), .cyc_end(cyc_end),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out),
        .p0_oe(p0_oe), .p2_out(p2_out), .rdata(rdata), .rdata_vld(rdata_vld)
    );

    int errs = 0, checks = 0;
    bit done = 1'b0;

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // external memory model answers from the latched address
    logic [15:0] lat_q = '0;
    assign p0_in = (!psen_n || !rd_n) ? mem(lat_q) : 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-window monitor state
    int n_ale, n_hi, n_psen, n_rd, n_wr, n_vld, n_lat, cyc_t;
    int v_addr, v_hiz, v_wr, v_hi;
    int rise_t [8];
    logic [15:0] lats [8];
    logic ale_p, psen_p, rd_p, wr_p;
    logic [7:0] p0_p, exp_wd;
    logic [15:0] exp_da;

    task automatic clear_mon();
        n_ale = 0; n_hi = 0; n_psen = 0; n_rd = 0; n_wr = 0; n_vld = 0; n_lat = 0;
        cyc_t = 0; v_addr = 0; v_hiz = 0; v_wr = 0; v_hi = 0;
        for (int i = 0; i < 8; i++) begin rise_t[i] = 0; lats[i] = '0; end
    endtask

    task automatic tick_mon();
        @(negedge clk);
        if (rdata_vld) begin
            n_vld++;
            chk(rdata == mem(lat_q), "R9 rdata", rdata, mem(lat_q));
        end
        if (ale && !ale_p) begin
            if (n_ale < 8) rise_t[n_ale] = cyc_t;
            n_ale++;
        end
        if (ale) n_hi++;
        if (!ale && ale_p) begin
            if (!p0_oe || p0_out != p0_p) v_addr++;
            lat_q = {p2_out, p0_out};
            if (n_lat < 8) lats[n_lat] = lat_q;
            n_lat++;
        end
        if (!psen_n && psen_p) n_psen++;
        if (!rd_n && rd_p) n_rd++;
        if (!wr_n && wr_p) n_wr++;
        if (!wr_n && (!p0_oe || p0_out != exp_wd)) v_wr++;
        if ((!psen_n || !rd_n) && p0_oe) v_hiz++;
        if ((!rd_n || !wr_n) && p2_out != exp_da[15:8]) v_hi++;
        ale_p = ale; psen_p = psen_n; rd_p = rd_n; wr_p = wr_n; p0_p = p0_out;
        cyc_t++;
    endtask

    task automatic run_mc(input logic f, input logic x, input logic w, input logic rom,
                          input logic [15:0] ca, input logic [15:0] da, input logic [7:0] wd);
        chk(cyc_end == 1'b1, "R10 cyc_end", cyc_end, 1);
        fetch_req = f; xdata_req = x; xdata_wr = w; rom_en = rom;
        code_addr = ca; data_addr = da; wdata = wd;
        repeat (12) tick_mon();
    endtask

    typedef struct packed {
        logic        f;
        logic        x;
        logic        w;
        logic        rom;
        logic [15:0] ca;
        logic [15:0] da;
        logic [7:0]  wd;
        logic [3:0]  n_ale;
        logic [3:0]  n_psen;
        logic [3:0]  n_rd;
        logic [3:0]  n_wr;
        logic [3:0]  n_vld;
        logic [15:0] lat1;
    } vec_t;

    // each window: the vector's machine cycle(s) followed by one idle cycle
    localparam vec_t VEC [8] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0123, 16'h0000, 8'h00, 4'd4, 4'd2, 4'd0, 4'd0, 4'd2, 16'h0124},
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'h0FFE, 16'h0000, 8'h00, 4'd4, 4'd0, 4'd0, 4'd0, 4'd0, 16'h0FFF},
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'h0FFF, 16'h0000, 8'h00, 4'd4, 4'd1, 4'd0, 4'd0, 4'd1, 16'h1000},
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'h1000, 16'h0000, 8'h00, 4'd4, 4'd2, 4'd0, 4'd0, 4'd2, 16'h1001},
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0050, 16'h0000, 8'h00, 4'd4, 4'd0, 4'd0, 4'd0, 4'd0, 16'h0051},
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'h2000, 16'h8042, 8'h00, 4'd5, 4'd2, 4'd1, 4'd0, 4'd3, 16'h8042},
        '{1'b1, 1'b1, 1'b1, 1'b1, 16'h0100, 16'h0033, 8'hA5, 4'd5, 4'd0, 4'd0, 4'd1, 4'd0, 16'h0033},
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF, 16'h0000, 8'h00, 4'd4, 4'd1, 4'd0, 4'd0, 4'd1, 16'h0000}
    };

    initial begin
        ale_p = 1'b0; psen_p = 1'b1; rd_p = 1'b1; wr_p = 1'b1; p0_p = '0;
        exp_wd = '0; exp_da = '0;
        clear_mon();

        // R10: state held in reset
        repeat (3) @(negedge clk);
        chk(ale == 1'b0, "R10 ale", ale, 0);
        chk(psen_n && rd_n && wr_n, "R10 strobes", {psen_n, rd_n, wr_n}, 3'b111);
        chk(p0_oe == 1'b0, "R10 p0_oe", p0_oe, 0);
        chk(rdata_vld == 1'b0, "R10 rdata_vld", rdata_vld, 0);
        chk(cyc_end == 1'b1, "R10 cyc_end", cyc_end, 1);
        rst_n = 1'b1;

        for (int v = 0; v < 8; v++) begin
            clear_mon();
            exp_wd = VEC[v].wd;
            exp_da = VEC[v].da;
            run_mc(VEC[v].f, VEC[v].x, VEC[v].w, VEC[v].rom, VEC[v].ca, VEC[v].da, VEC[v].wd);
            if (VEC[v].x)
                run_mc(VEC[v].f, 1'b0, VEC[v].w, VEC[v].rom, VEC[v].ca, VEC[v].da, VEC[v].wd);
            run_mc(1'b0, 1'b0, 1'b0, VEC[v].rom, VEC[v].ca, 16'h0000, 8'h00);

            chk(n_ale == int'(VEC[v].n_ale), "R1/R2 ale pulses", n_ale, VEC[v].n_ale);
            chk(n_hi == 2 * n_ale, "R1 ale width", n_hi, 2 * n_ale);
            chk(n_psen == int'(VEC[v].n_psen), "R5/R6 psen pulses", n_psen, VEC[v].n_psen);
            chk(n_rd == int'(VEC[v].n_rd), "R7 rd pulses", n_rd, VEC[v].n_rd);
            chk(n_wr == int'(VEC[v].n_wr), "R7 wr pulses", n_wr, VEC[v].n_wr);
            chk(n_vld == int'(VEC[v].n_vld), "R9 valid count", n_vld, VEC[v].n_vld);
            chk(lats[0] == VEC[v].ca, "R4 first latch", lats[0], VEC[v].ca);
            chk(lats[1] == VEC[v].lat1, "R4 second latch", lats[1], VEC[v].lat1);
            chk(v_addr == 0, "R3 address hold", v_addr, 0);
            chk(v_hiz == 0, "R8 port released", v_hiz, 0);
            chk(v_wr == 0, "R7 write data", v_wr, 0);
            chk(v_hi == 0, "R4 high byte in strobe", v_hi, 0);
            chk(rise_t[0] == 0 && rise_t[1] == 6, "R1 ale phase", rise_t[1], 6);
            if (VEC[v].x) begin
                chk(rise_t[2] - rise_t[1] == 12, "R2 skipped pulse", rise_t[2] - rise_t[1], 12);
                chk(lats[2] == VEC[v].ca, "R4 fetch after strobe", lats[2], VEC[v].ca);
            end else begin
                chk(rise_t[2] - rise_t[1] == 6, "R1 ale period", rise_t[2] - rise_t[1], 6);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule